// File: doc/BRIEF.md
# Five-Stage Shift Register with Level-Sensitive Parallel Load

This block is a five-stage serial-in, parallel-out shift register. A parallel load bypasses the clock. While the load input is high, every stage takes the value of its parallel data bit at once and keeps following that bit for as long as load stays high. Clock edges have no effect during that time.

While load is low, each rising clock edge moves the contents one stage toward the far end. The serial input enters the first stage, and whatever the last stage held is lost. When load drops, the register keeps the loaded pattern until the next rising edge. This makes it usable as a parallel-loaded pattern source that is then clocked out, or as a plain serial-to-parallel converter.

An asynchronous active-low reset clears all stages at once. Its release is synchronised to the clock, so shifting starts a fixed number of edges after the reset pin rises.

Top module: `par_load_shifter`

## Requirements
- R1: While `rst_n` is low, `q` is 00000 with no clock edge needed, whatever `ld`, `ser` and `d` do.
- R2: While `ld` is high (and reset is released), `q` equals `d` without any clock edge, and follows every change of `d`.
- R3: While `ld` is high and `d` is stable, a rising clock edge leaves `q` unchanged.
- R4: While `ld` is low, a rising clock edge sets `q[i]` to the previous `q[i-1]` for i = 1..4. Bit 0 is the first stage and bit 4 is the last.
- R5: On that same shift, `q[0]` takes the value of `ser` sampled at the edge.
- R6: After `ld` falls, `q` holds the last loaded value until the next rising edge, even if `d` changes.
- R7: The previous `q[4]` is discarded on a shift: after five shifts with serial values s1..s5 in that order, `q[4:0]` = s1 s2 s3 s4 s5, independent of the earlier contents.
- R8: After `rst_n` rises between edges, the first two rising edges leave `q` at 00000. The third edge performs the first shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| ld | input | 1 | Level-sensitive parallel load, active high |
| ser | input | 1 | Serial data entering stage 0 |
| d | input | 5 | Parallel data, bit 0 for the first stage |
| q | output | 5 | Stage contents, bit 0 is the first stage |

## Verification
The clocked properties assume that `ld`, `ser` and `d` change only away from rising clock edges. They also assume that a load pulse spans at least one rising edge, so that the sampled value of `ld` at each edge tells whether a shift took place. They further assume that `ld` is low when the internal reset releases. If a flop has its asynchronous load held while reset releases, it only adopts `d` at the next edge. The stimulus changes every input on the falling clock edge or shortly after it, keeps each load high across at least one rising edge, and drops `ld` before raising `rst_n`.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned PLS_WIDTH_DEF = 5;
  localparam int unsigned PLS_SYNC_DEF  = 2;
endpackage

// File: rtl/pls_rst_sync.sv
module pls_rst_sync #(
  parameter int unsigned STAGES = pls_pkg::PLS_SYNC_DEF
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/pls_stage.sv
module pls_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic load_bit,
  input  logic shift_in,
  output logic q_bit
);
  logic force_hi;
  logic force_lo;
  logic shift_en;
  logic q_nxt;

  always_comb begin
    force_hi = ld & load_bit;
    force_lo = ld & ~load_bit;
    shift_en = ~ld;
    q_nxt    = shift_in;
  end

  always_ff @(posedge clk or negedge rst_n or posedge force_hi or posedge force_lo) begin
    if (!rst_n)        q_bit <= 1'b0;
    else if (force_hi) q_bit <= 1'b1;
    else if (force_lo) q_bit <= 1'b0;
    else if (shift_en) q_bit <= q_nxt;
  end
endmodule

// File: rtl/par_load_shifter.sv
module par_load_shifter #(
  parameter int unsigned WIDTH       = pls_pkg::PLS_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = pls_pkg::PLS_SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             ser,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] feed;

  pls_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  always_comb begin
    feed = {q[WIDTH-2:0], ser};
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    pls_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ld       (ld),
      .load_bit (d[i]),
      .shift_in (feed[i]),
      .q_bit    (q[i])
    );
  end
endmodule

// File: rtl/pls_checker.sv
module pls_checker #(
  parameter int unsigned WIDTH = pls_pkg::PLS_WIDTH_DEF
) (
  input logic             clk,
  input logic             arst_n,
  input logic             srst_n,
  input logic             ld,
  input logic             ser,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !arst_n |-> q == '0); // R1

  AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!srst_n)
    ld |-> q == d); // R2

  AST_LOAD_BLOCKS_CLOCK: assert property (@(posedge clk) disable iff (!srst_n)
    (ld && $past(ld) && $stable(d)) |-> $stable(q)); // R3

  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!srst_n)
    (!ld && !$past(ld) && $past(srst_n)) |-> q[WIDTH-1:1] == $past(q[WIDTH-2:0])); // R4

  AST_SER_ENTERS: assert property (@(posedge clk) disable iff (!srst_n)
    (!ld && !$past(ld) && $past(srst_n)) |-> q[0] == $past(ser)); // R5
endmodule

bind par_load_shifter pls_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .arst_n (rst_n),
  .srst_n (rst_sync_n),
  .ld     (ld),
  .ser    (ser),
  .d      (d),
  .q      (q)
);

// File: tb/par_load_shifter_test.sv
`timescale 1ns/1ps
module par_load_shifter_test;
  logic       clk;
  logic       rst_n;
  logic       ld;
  logic       ser;
  logic [4:0] d;
  logic [4:0] q;
  int checks;
  int failures;
  bit done;

  par_load_shifter uut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ser(ser), .d(d), .q(q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // entry: {ld, ser, d[4:0], expected q[4:0] after the next rising edge}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'b10110, 5'b10110},  // R2 load
    {1'b1, 1'b1, 5'b01001, 5'b01001},  // R3 clock ignored under load
    {1'b0, 1'b1, 5'b00000, 5'b10011},  // R4 R5 shift
    {1'b0, 1'b0, 5'b00000, 5'b00110},
    {1'b0, 1'b1, 5'b00000, 5'b01101},
    {1'b0, 1'b1, 5'b00000, 5'b11011},
    {1'b0, 1'b0, 5'b00000, 5'b10110},
    {1'b1, 1'b0, 5'b11111, 5'b11111},  // R2
    {1'b0, 1'b0, 5'b00000, 5'b11110},  // R6 shift starts from loaded value
    {1'b0, 1'b0, 5'b00000, 5'b11100},
    {1'b0, 1'b1, 5'b00000, 5'b11001},
    {1'b0, 1'b0, 5'b00000, 5'b10010},
    {1'b0, 1'b0, 5'b00000, 5'b00100}   // R7 old stage 4 dropped
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s q=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #2;
  endtask

  // R8: release reset between edges, two edges without shifting, third shifts
  task automatic release_reset();
    @(negedge clk);
    ld  = 1'b0;
    ser = 1'b1;
    rst_n = 1'b1;
    edge_sample(); check("R8", q, 5'b00000);
    edge_sample(); check("R8", q, 5'b00000);
    edge_sample(); check("R8", q, 5'b00001);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b1; ld = 1'b0; ser = 1'b1; d = 5'b00000;
    #2 rst_n = 1'b0;
    #1 check("R1", q, 5'b00000);
    repeat (3) edge_sample();
    check("R1", q, 5'b00000);
    release_reset();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ld  = VEC[i][11];
      ser = VEC[i][10];
      d   = VEC[i][9:5];
      edge_sample();
      check("R2 R3 R4 R5 R6 R7 vector", q, VEC[i][4:0]);
    end

    // R2: load tracks d with no clock edge
    @(negedge clk);
    ld = 1'b1; d = 5'b01100;
    #1 check("R2", q, 5'b01100);
    d = 5'b10011;
    #1 check("R2", q, 5'b10011);
    // R3: edges with ld high and d stable
    edge_sample(); check("R3", q, 5'b10011);
    edge_sample(); check("R3", q, 5'b10011);

    // R6: hold after ld falls, d changes ignored
    @(negedge clk);
    d = 5'b10101;
    #1 check("R2", q, 5'b10101);
    edge_sample();
    @(negedge clk);
    ld = 1'b0; ser = 1'b0; d = 5'b01010;
    #1 check("R6", q, 5'b10101);
    #2 check("R6", q, 5'b10101);
    edge_sample(); check("R4", q, 5'b01010);

    // R7: five shifts fully replace contents, s1..s5 = 1,1,0,1,0
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      ser = (k == 2 || k == 4) ? 1'b0 : 1'b1;
      edge_sample();
    end
    check("R7", q, 5'b11010);

    // R1: reset mid-run dominates a pending load
    @(negedge clk);
    ld = 1'b1; d = 5'b11111;
    #1 check("R2", q, 5'b11111);
    rst_n = 1'b0;
    #1 check("R1", q, 5'b00000);
    edge_sample(); check("R1", q, 5'b00000);
    release_reset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired q=%b expected=done", q);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule